// File: doc/BRIEF.md
# Memory Fault Status Register

This block gathers error reports from the memory system into sticky status flags. Four groups of detectors feed it with single-cycle pulses: the store path on the system bus, the L2 fill path, the L2 internal-read path and the D1 cache path. Each flag stays set until software clears it by writing a one to its position. While any flag is set, the block raises an interrupt request. It also presents a priority code for the most severe flag that is set.

Besides recording the events, the block tells the error-marking logic which mark ID to stamp on a damaged doubleword. Corrupted data that arrives from the bus during a fill is marked with ID zero. Corruption found inside the L2 or D1 arrays is marked with the value of a software-written ID register, captured in the cycle the event occurs. Mark requests leave through a small ordered queue that issues one valid pulse per request. When a fill request and an internal request arrive together, the fill request goes first.

Top module: `fault_status_reg`

## Requirements
- R1: Status bit 3 (store dropped) becomes 1 at the clock edge that samples a pulse on `ev_store_buserr` or on `ev_store_timeout`.
- R2: Status bit 2 (raw error in fill data) becomes 1 at the edge that samples a pulse on `ev_fill_ue`.
- R3: Status bit 1 (raw error inside L2 data) becomes 1 only when `ev_l2_ue` is sampled with `l2_src` = 2 (writeback). Codes 0 (D1/I1 fill read), 1 (copyback) and 3 (unused) leave bit 1 and the mark output untouched.
- R4: Status bit 0 (raw error inside D1 data) becomes 1 on a pulse of `ev_d1_load_ue`, `ev_d1_store_drop` or `ev_d1_wb_ue`.
- R5: A write with `reg_wr_en` clears each status bit at a position where `reg_wdata` holds 1 and leaves the other bits as they are. If a set event and a clear of the same bit meet in one cycle, the bit reads 1 afterwards.
- R6: `reg_rdata` bits DATA_W-1..4 always read 0. Writing ones to them changes nothing.
- R7: Each sampled fill event queues one mark request with ID 0. While the queue is not empty, `mark_valid` is high and `mark_id` shows its oldest entry. Each entry is shown for exactly one cycle, so with an empty queue the request appears in the cycle after the event.
- R8: A cycle that sets bit 1 or bit 0 (or both) queues one mark request carrying the ID register value held in that cycle. An `id_wr_en` write in the same cycle affects only later events.
- R9: When fill and internal requests come in the same cycle, the fill request (ID 0) is queued ahead of the internal one. The queue holds at most MARK_DEPTH pending entries, and a request that finds it full is dropped.
- R10: `prio_code` reads 8'hC0 when bit 1 is set. Otherwise it reads 8'h80 when bit 2 or bit 0 is set, and 8'h00 in all other cases.
- R11: `irq` is high exactly while any of status bits 3..0 is 1.
- R12: After reset the status bits, the ID register and the mark queue are all clear, and `irq` and `mark_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_store_buserr | input | 1 | Completed store lost to a bus error |
| ev_store_timeout | input | 1 | Completed store lost to a bus timeout |
| ev_fill_ue | input | 1 | Raw uncorrectable error in incoming L2 fill data |
| ev_l2_ue | input | 1 | Raw uncorrectable error read from L2 data |
| l2_src | input | 2 | Read type for `ev_l2_ue`: 0 fill read, 1 copyback, 2 writeback |
| ev_d1_load_ue | input | 1 | Raw error in D1 data read by a load or store |
| ev_d1_store_drop | input | 1 | Completed store dropped because of a D1 error |
| ev_d1_wb_ue | input | 1 | Raw error in D1 data during writeback to L2 |
| reg_wr_en | input | 1 | Status write strobe (write-one-to-clear) |
| reg_wdata | input | DATA_W | Status write data |
| reg_rdata | output | DATA_W | Status read data |
| id_wr_en | input | 1 | Mark ID register write strobe |
| id_wdata | input | ID_W | Mark ID register write data |
| mark_valid | output | 1 | One pulse per queued mark request |
| mark_id | output | ID_W | Mark ID for the current request |
| prio_code | output | 8 | Priority code of the most severe set flag |
| irq | output | 1 | Interrupt request, high while any flag is set |

## Verification
The bench targets several corner cases:
- A set and a clear of the same bit in one cycle. A design that lets the clear win loses the event.
- L2 reads of the non-writeback kinds. A design that decodes `l2_src` loosely would set bit 1 and emit a spurious mark.
- An ID register write in the same cycle as an internal event. Here the old ID must be stamped, and a design that bypasses the new value would show it one request too early.
- Coincident fill and internal events, including bursts that fill the queue past MARK_DEPTH. Wrong ordering would show the stored ID before zero, and wrong full accounting would either drop requests that fit or emit ones that should have been lost.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   localparam int NB        = 4;
   localparam int BIT_STORE = 3;
   localparam int BIT_FILL  = 2;
   localparam int BIT_L2    = 1;
   localparam int BIT_D1    = 0;

   localparam logic [7:0] PRIO_L2   = 8'hC0;
   localparam logic [7:0] PRIO_D1   = 8'h80;
   localparam logic [7:0] PRIO_NONE = 8'h00;

   typedef enum logic [1:0] {
      L2_FILL_RD  = 2'd0,
      L2_COPYBACK = 2'd1,
      L2_WRBACK   = 2'd2,
      L2_UNUSED   = 2'd3
   } l2_src_e;

   typedef struct packed {
      logic fill;
      logic internal;
   } mark_req_t;
endpackage

// File: rtl/fsr_event_decode.sv
module fsr_event_decode
   import fsr_pkg::*;
(
   input  logic              store_buserr,
   input  logic              store_timeout,
   input  logic              fill_ue,
   input  logic              l2_ue,
   input  l2_src_e           l2_src,
   input  logic              d1_load_ue,
   input  logic              d1_store_drop,
   input  logic              d1_wb_ue,
   output logic [NB-1:0]     set_vec,
   output mark_req_t         req
);
   always_comb begin
      set_vec            = '0;
      set_vec[BIT_STORE] = store_buserr | store_timeout;
      set_vec[BIT_FILL]  = fill_ue;
      // only the writeback path records an L2 internal error
      set_vec[BIT_L2]    = l2_ue && (l2_src == L2_WRBACK);
      set_vec[BIT_D1]    = d1_load_ue | d1_store_drop | d1_wb_ue;
      req.fill           = set_vec[BIT_FILL];
      req.internal       = set_vec[BIT_L2] | set_vec[BIT_D1];
   end
endmodule

// File: rtl/fsr_sticky_bits.sv
module fsr_sticky_bits #(
   parameter int NBITS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] set_vec,
   input  logic [NBITS-1:0] clr_vec,
   output logic [NBITS-1:0] q
);
   for (genvar i = 0; i < NBITS; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)          q[i] <= 1'b0;
         else if (set_vec[i]) q[i] <= 1'b1;
         else if (clr_vec[i]) q[i] <= 1'b0;
      end

      // R5: set beats a simultaneous clear
      assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
         set_vec[i] |=> q[i]);
      // R5: a clear without a set empties the bit
      assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_vec[i] && !set_vec[i]) |=> !q[i]);
      // R5: no set and no clear leaves the bit alone
      assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_vec[i] && !set_vec[i]) |=> $stable(q[i]));
   end
endmodule

// File: rtl/fsr_mark_queue.sv
module fsr_mark_queue #(
   parameter int ID_W  = 8,
   parameter int DEPTH = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push_fill,
   input  logic            push_int,
   input  logic [ID_W-1:0] int_id,
   output logic            valid,
   output logic [ID_W-1:0] id_out
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [ID_W-1:0] mem [DEPTH];
   logic [PW-1:0]   rd_ptr, wr_ptr;
   logic [CW-1:0]   cnt, base, room, n_push;
   logic            pop, ok_a, ok_b;
   logic [ID_W-1:0] first_id;

   always_comb begin
      pop      = (cnt != '0);
      base     = cnt - CW'(pop);
      room     = CW'(DEPTH) - base;
      ok_a     = push_fill && (room != '0);
      ok_b     = push_int && (ok_a ? (room >= CW'(2)) : (room != '0));
      first_id = ok_a ? '0 : int_id;
      n_push   = CW'(ok_a) + CW'(ok_b);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (pop) rd_ptr <= rd_ptr + PW'(1);
         wr_ptr <= wr_ptr + PW'(ok_a) + PW'(ok_b);
         cnt    <= base + n_push;
      end
   end

   always_ff @(posedge clk) begin
      if (ok_a || ok_b)  mem[wr_ptr] <= first_id;
      if (ok_a && ok_b)  mem[wr_ptr + PW'(1)] <= int_id;
   end

   assign valid  = (cnt != '0);
   assign id_out = mem[rd_ptr];

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   // R9: fill goes ahead of a coincident internal request
   assert_fill_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (push_fill && push_int && cnt == '0) |=> (valid && id_out == '0) ##1 valid);
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
   import fsr_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ID_W       = 8,
   parameter int MARK_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_store_buserr,
   input  logic              ev_store_timeout,
   input  logic              ev_fill_ue,
   input  logic              ev_l2_ue,
   input  logic [1:0]        l2_src,
   input  logic              ev_d1_load_ue,
   input  logic              ev_d1_store_drop,
   input  logic              ev_d1_wb_ue,
   input  logic              reg_wr_en,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              id_wr_en,
   input  logic [ID_W-1:0]   id_wdata,
   output logic              mark_valid,
   output logic [ID_W-1:0]   mark_id,
   output logic [7:0]        prio_code,
   output logic              irq
);
   if (DATA_W < NB) begin : g_chk_dw
      $error("DATA_W must hold all status bits");
   end
   if (ID_W < 1) begin : g_chk_id
      $error("ID_W must be at least 1");
   end
   if (MARK_DEPTH < 2 || (MARK_DEPTH & (MARK_DEPTH - 1)) != 0) begin : g_chk_md
      $error("MARK_DEPTH must be a power of two, at least 2");
   end

   logic [NB-1:0]   set_vec, clr_vec, status;
   mark_req_t       req;
   logic [ID_W-1:0] id_q;

   fsr_event_decode u_dec (
      .store_buserr  (ev_store_buserr),
      .store_timeout (ev_store_timeout),
      .fill_ue       (ev_fill_ue),
      .l2_ue         (ev_l2_ue),
      .l2_src        (l2_src_e'(l2_src)),
      .d1_load_ue    (ev_d1_load_ue),
      .d1_store_drop (ev_d1_store_drop),
      .d1_wb_ue      (ev_d1_wb_ue),
      .set_vec       (set_vec),
      .req           (req)
   );

   assign clr_vec = reg_wr_en ? reg_wdata[NB-1:0] : '0;

   fsr_sticky_bits #(.NBITS(NB)) u_bits (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .q       (status)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        id_q <= '0;
      else if (id_wr_en) id_q <= id_wdata;
   end

   fsr_mark_queue #(.ID_W(ID_W), .DEPTH(MARK_DEPTH)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_fill (req.fill),
      .push_int  (req.internal),
      .int_id    (id_q),
      .valid     (mark_valid),
      .id_out    (mark_id)
   );

   assign reg_rdata = DATA_W'(status);
   assign irq       = |status;

   always_comb begin
      if (status[BIT_L2])                       prio_code = PRIO_L2;
      else if (status[BIT_FILL] | status[BIT_D1]) prio_code = PRIO_D1;
      else                                      prio_code = PRIO_NONE;
   end

   assert_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_store_buserr || ev_store_timeout) |=> reg_rdata[BIT_STORE]);
   assert_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_fill_ue |=> reg_rdata[BIT_FILL]);
   assert_l2_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_l2_ue && l2_src == 2'd2) |=> reg_rdata[BIT_L2]);
   assert_d1_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_d1_load_ue || ev_d1_store_drop || ev_d1_wb_ue) |=> reg_rdata[BIT_D1]);
   assert_fill_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_fill_ue && !mark_valid) |=> (mark_valid && mark_id == '0));
   assert_int_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req.internal && !ev_fill_ue && !mark_valid) |=> (mark_valid && mark_id == $past(id_q)));
   assert_prio_l2_R10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[BIT_L2] |-> prio_code == 8'hC0);
   assert_irq_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(|set_vec));

   if (DATA_W > NB) begin : g_rsvd
      assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
         reg_rdata[DATA_W-1:NB] == '0);
      assert_rsvd_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr_en && |reg_wdata[DATA_W-1:NB]) |=> reg_rdata[DATA_W-1:NB] == '0);
   end
endmodule

// File: tb/fault_status_reg_test.sv
`timescale 1ns/1ps
module fault_status_reg_test;
   localparam int DW = 32;
   localparam int IW = 8;
   localparam int MD = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_store_buserr = 0, ev_store_timeout = 0, ev_fill_ue = 0, ev_l2_ue = 0;
   logic [1:0] l2_src = 0;
   logic ev_d1_load_ue = 0, ev_d1_store_drop = 0, ev_d1_wb_ue = 0;
   logic reg_wr_en = 0;
   logic [DW-1:0] reg_wdata = 0;
   logic [DW-1:0] reg_rdata;
   logic id_wr_en = 0;
   logic [IW-1:0] id_wdata = 0;
   logic mark_valid;
   logic [IW-1:0] mark_id;
   logic [7:0] prio_code;
   logic irq;

   int checks = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   fault_status_reg #(.DATA_W(DW), .ID_W(IW), .MARK_DEPTH(MD)) uut (
      .clk(clk), .rst_n(rst_n),
      .ev_store_buserr(ev_store_buserr), .ev_store_timeout(ev_store_timeout),
      .ev_fill_ue(ev_fill_ue), .ev_l2_ue(ev_l2_ue), .l2_src(l2_src),
      .ev_d1_load_ue(ev_d1_load_ue), .ev_d1_store_drop(ev_d1_store_drop),
      .ev_d1_wb_ue(ev_d1_wb_ue),
      .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .id_wr_en(id_wr_en), .id_wdata(id_wdata),
      .mark_valid(mark_valid), .mark_id(mark_id),
      .prio_code(prio_code), .irq(irq)
   );

   // behavioural reference model
   logic [3:0]  m_st = 0;
   logic [IW-1:0] m_id = 0;
   int unsigned m_q[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0;
         m_id = 0;
         m_q.delete();
      end else begin
         logic [3:0] s;
         logic [3:0] c;
         s[3] = ev_store_buserr | ev_store_timeout;
         s[2] = ev_fill_ue;
         s[1] = ev_l2_ue && (l2_src == 2'd2);
         s[0] = ev_d1_load_ue | ev_d1_store_drop | ev_d1_wb_ue;
         c = reg_wr_en ? reg_wdata[3:0] : 4'b0;
         m_st = (m_st & ~c) | s;
         if (m_q.size() > 0) void'(m_q.pop_front());
         if (s[2] && m_q.size() < MD) m_q.push_back(0);
         if ((s[1] | s[0]) && m_q.size() < MD) m_q.push_back(int'(m_id));
         if (id_wr_en) m_id = id_wdata;
      end
   end

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] exp_prio(logic [3:0] st);
      if (st[1]) return 8'hC0;
      if (st[2] | st[0]) return 8'h80;
      return 8'h00;
   endfunction

   bit cmp_on = 0;
   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         chk("R1 store bit", 64'(reg_rdata[3]), 64'(m_st[3]));
         chk("R2 fill bit", 64'(reg_rdata[2]), 64'(m_st[2]));
         chk("R3 l2 bit", 64'(reg_rdata[1]), 64'(m_st[1]));
         chk("R4 d1 bit", 64'(reg_rdata[0]), 64'(m_st[0]));
         chk("R6 reserved", 64'(reg_rdata[DW-1:4]), 64'(0));
         chk("R10 prio", 64'(prio_code), 64'(exp_prio(m_st)));
         chk("R11 irq", 64'(irq), 64'(|m_st));
         chk("R7 mark_valid", 64'(mark_valid), 64'(m_q.size() > 0));
         if (m_q.size() > 0)
            chk("R8 R9 mark_id", 64'(mark_id), 64'(m_q[0]));
      end
   end

   task automatic idle_inputs();
      ev_store_buserr = 0; ev_store_timeout = 0; ev_fill_ue = 0; ev_l2_ue = 0;
      l2_src = 0; ev_d1_load_ue = 0; ev_d1_store_drop = 0; ev_d1_wb_ue = 0;
      reg_wr_en = 0; reg_wdata = 0; id_wr_en = 0; id_wdata = 0;
   endtask

   task automatic step();
      @(negedge clk);
      #1;
      idle_inputs();
   endtask

   task automatic clear_all();
      reg_wr_en = 1; reg_wdata = '1;
      step();
   endtask

   initial begin
      #(5.0 * 100000);
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      idle_inputs();
      repeat (3) @(negedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R12: reset state
      chk("R12 rdata", 64'(reg_rdata), 64'(0));
      chk("R12 irq", 64'(irq), 64'(0));
      chk("R12 mark_valid", 64'(mark_valid), 64'(0));
      chk("R12 prio", 64'(prio_code), 64'(0));
      #1 cmp_on = 1;

      // R1
      ev_store_buserr = 1; step(); step();
      clear_all();
      ev_store_timeout = 1; step(); step();
      clear_all();
      // R2, R7
      ev_fill_ue = 1; step(); step(); step();
      clear_all();
      // R3: non-writeback kinds are ignored
      for (int k = 0; k < 4; k++) begin
         if (k != 2) begin
            ev_l2_ue = 1; l2_src = 2'(k); step(); step();
         end
      end
      ev_l2_ue = 1; l2_src = 2'd2; step(); step();
      clear_all();
      // R4
      ev_d1_load_ue = 1; step(); clear_all();
      ev_d1_store_drop = 1; step(); clear_all();
      ev_d1_wb_ue = 1; step(); clear_all();
      // R5: partial clears, zero writes, set against clear
      ev_store_buserr = 1; ev_fill_ue = 1; ev_d1_wb_ue = 1; step();
      reg_wr_en = 1; reg_wdata = 0; step();
      reg_wr_en = 1; reg_wdata = 32'h4; step();
      reg_wr_en = 1; reg_wdata = 32'h9; ev_d1_load_ue = 1; step(); step();
      clear_all();
      // R6: reserved writes
      ev_fill_ue = 1; step();
      reg_wr_en = 1; reg_wdata = 32'hFFFF_FFF0; step(); step();
      clear_all();
      // R8: ID register, write in the event cycle
      id_wr_en = 1; id_wdata = 8'h5A; step();
      ev_d1_load_ue = 1; step(); step();
      ev_l2_ue = 1; l2_src = 2'd2; id_wr_en = 1; id_wdata = 8'hC3; step();
      ev_d1_wb_ue = 1; ev_l2_ue = 1; l2_src = 2'd2; step(); step();
      clear_all();
      // R9: coincident fill and internal, then overflow burst
      ev_fill_ue = 1; ev_d1_store_drop = 1; step(); step(); step();
      for (int k = 0; k < 5; k++) begin
         ev_fill_ue = 1; ev_l2_ue = 1; l2_src = 2'd2;
         id_wr_en = 1; id_wdata = 8'(8'h10 + k);
         step();
      end
      repeat (6) step();
      clear_all();
      // mixed traffic
      for (int k = 0; k < 400; k++) begin
         ev_store_buserr  = ($urandom % 8) == 0;
         ev_store_timeout = ($urandom % 8) == 0;
         ev_fill_ue       = ($urandom % 5) == 0;
         ev_l2_ue         = ($urandom % 4) == 0;
         l2_src           = 2'($urandom);
         ev_d1_load_ue    = ($urandom % 9) == 0;
         ev_d1_store_drop = ($urandom % 9) == 0;
         ev_d1_wb_ue      = ($urandom % 9) == 0;
         reg_wr_en        = ($urandom % 3) == 0;
         reg_wdata        = $urandom;
         id_wr_en         = ($urandom % 4) == 0;
         id_wdata         = 8'($urandom);
         step();
      end
      repeat (8) step();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule